// File: doc/BRIEF.md
# Mixed Page-Size Translation Buffer

A small fully associative buffer that turns virtual addresses into physical addresses. Each slot holds one translation for a 4 KiB, 2 MiB or 1 GiB page. The size of the page that covers an address is not known when the lookup starts. Every slot masks the incoming address to the width its own size code implies and compares only the bits above that offset. When a slot matches, its size code fixes how many low address bits pass through untranslated. Those offset bits are placed below the slot's frame bits to form the physical address, and the size is reported alongside it.

Lookup is purely combinational. A miss is flagged so that an external page walker can resolve the address and return the translation as a refill. Refills use a valid/ready handshake. A refill is taken on a rising clock edge only when `rf_valid` and `rf_ready` are both high. `rf_ready` is low in any cycle where `flush` is asserted. A producer facing a low ready must hold its refill until ready returns. The slot that receives a refill is picked by a round-robin pointer.

A flush clears every slot in one cycle. Permissions, address-space tags and the walker itself are outside this block.

Top module: `mixed_tlb`

## Requirements
- R1: After reset every slot is invalid, every lookup misses, `rf_ready` is high and the replacement pointer is at slot 0.
- R2: A slot with size code 00 (4 KiB) matches when vaddr[47:12] equals its VPN. The physical address is then {PFN[27:0], vaddr[11:0]} and `lk_size` is 00.
- R3: A slot with size code 01 (2 MiB) matches when vaddr[47:21] equals VPN[35:9]. The physical address is then {PFN[27:9], vaddr[20:0]} and `lk_size` is 01.
- R4: A slot with size code 10 (1 GiB) matches when vaddr[47:30] equals VPN[35:18]. The physical address is then {PFN[27:18], vaddr[29:0]} and `lk_size` is 10.
- R5: A slot written with size code 11 never matches any address.
- R6: When `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high. When `lk_valid` is low, both are low. Whenever `lk_hit` is low, `lk_paddr` and `lk_size` are zero.
- R7: When several valid slots match, the translation comes from the lowest-numbered one.
- R8: An accepted refill writes the slot under the pointer, marks it valid, and advances the pointer by one, wrapping from slot 15 to slot 0. The new translation is visible to lookups from the next cycle.
- R9: A cycle with `flush` high invalidates every slot and returns the pointer to 0. In that cycle `rf_ready` is low and no refill is taken. From the next cycle every lookup misses until a refill is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all slots this cycle |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_miss | output | 1 | Lookup matched no slot; walk needed |
| lk_paddr | output | 40 | Translated physical address (zero unless hit) |
| lk_size | output | 2 | Size code of the matching slot (zero unless hit) |
| rf_valid | input | 1 | Refill entry offered |
| rf_ready | output | 1 | Refill can be taken this cycle |
| rf_vpn | input | 36 | Refill virtual page number (vaddr[47:12]) |
| rf_pfn | input | 28 | Refill physical frame number (paddr[39:12]) |
| rf_size | input | 2 | Refill size code: 00 4 KiB, 01 2 MiB, 10 1 GiB, 11 invalid |

## Verification
The bench probes large pages with addresses that differ from the stored VPN only in bits the page size should ignore. A design that compared a fixed 36-bit page number would miss on these. It also checks that the returned offset takes exactly the pass-through width, so a wrong split would corrupt frame or offset bits. Overlapping 2 MiB and 4 KiB slots are loaded in both orders to catch a priority inverted toward the highest slot. The bench also fills past sixteen refills to show the oldest slot is overwritten, which a stuck or non-wrapping pointer would get wrong. It issues a refill in the same cycle as a flush, which a design that let the refill through would expose as a stale hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K  = 2'b00,
    PG_2M  = 2'b01,
    PG_1G  = 2'b10,
    PG_BAD = 2'b11
  } pg_size_e;

  localparam int OFF_4K = 12;
  localparam int OFF_2M = 21;
  localparam int OFF_1G = 30;

  // page-number bits that a larger page leaves untranslated
  localparam int SPAN_2M = OFF_2M - OFF_4K;
  localparam int SPAN_1G = OFF_1G - OFF_4K;

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
  import tlb_pkg::*;
#(
  parameter int VPN_W = 36,
  parameter int PFN_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  pg_size_e         wr_size,
  input  logic [VPN_W-1:0] q_vpn,
  output logic             match,
  output logic [PFN_W-1:0] frame,
  output pg_size_e         size
);

  logic             vld;
  logic [VPN_W-1:0] vpn_q;
  logic [PFN_W-1:0] pfn_q;
  pg_size_e         size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      vpn_q  <= '0;
      pfn_q  <= '0;
      size_q <= PG_4K;
    end else if (clr) begin
      vld <= 1'b0;
    end else if (we) begin
      vld    <= 1'b1;
      vpn_q  <= wr_vpn;
      pfn_q  <= wr_pfn;
      size_q <= wr_size;
    end
  end

  logic eq_hi_1g, eq_mid_2m, eq_lo_4k;
  assign eq_hi_1g  = (q_vpn[VPN_W-1:SPAN_1G]   == vpn_q[VPN_W-1:SPAN_1G]);
  assign eq_mid_2m = (q_vpn[SPAN_1G-1:SPAN_2M] == vpn_q[SPAN_1G-1:SPAN_2M]);
  assign eq_lo_4k  = (q_vpn[SPAN_2M-1:0]       == vpn_q[SPAN_2M-1:0]);

  always_comb begin
    match = 1'b0;
    frame = pfn_q;
    unique case (size_q)
      PG_4K: begin
        match = vld && eq_hi_1g && eq_mid_2m && eq_lo_4k;
        frame = pfn_q;
      end
      PG_2M: begin
        match = vld && eq_hi_1g && eq_mid_2m;
        frame = {pfn_q[PFN_W-1:SPAN_2M], q_vpn[SPAN_2M-1:0]};
      end
      PG_1G: begin
        match = vld && eq_hi_1g;
        frame = {pfn_q[PFN_W-1:SPAN_1G], q_vpn[SPAN_1G-1:0]};
      end
      default: begin
        match = 1'b0;
        frame = pfn_q;
      end
    endcase
  end

  assign size = size_q;

endmodule

// File: rtl/tlb_first_match.sv
module tlb_first_match #(
  parameter int N     = 16,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N   = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] ptr
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (clr)    ptr <= '0;
    else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

endmodule

// File: rtl/mixed_tlb.sv
module mixed_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int ENTRIES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 lk_valid,
  input  logic [VA_W-1:0]      lk_vaddr,
  output logic                 lk_hit,
  output logic                 lk_miss,
  output logic [PA_W-1:0]      lk_paddr,
  output logic [1:0]           lk_size,
  input  logic                 rf_valid,
  output logic                 rf_ready,
  input  logic [VA_W-13:0]     rf_vpn,
  input  logic [PA_W-13:0]     rf_pfn,
  input  logic [1:0]           rf_size
);

  localparam int VPN_W = VA_W - OFF_4K;
  localparam int PFN_W = PA_W - OFF_4K;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] q_vpn;
  logic [IW-1:0]    wr_ptr;
  logic             take;
  logic [ENTRIES-1:0] hit_vec;
  logic [PFN_W-1:0] frame_arr [ENTRIES];
  pg_size_e         size_arr  [ENTRIES];
  logic             any_hit;
  logic [IW-1:0]    win;

  assign q_vpn    = lk_vaddr[VA_W-1:OFF_4K];
  assign rf_ready = !flush;
  assign take     = rf_valid && rf_ready;

  tlb_rr_ptr #(.N(ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(flush), .adv(take), .ptr(wr_ptr)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (flush),
      .we      (take && (wr_ptr == IW'(g))),
      .wr_vpn  (rf_vpn),
      .wr_pfn  (rf_pfn),
      .wr_size (pg_size_e'(rf_size)),
      .q_vpn   (q_vpn),
      .match   (hit_vec[g]),
      .frame   (frame_arr[g]),
      .size    (size_arr[g])
    );
  end

  tlb_first_match #(.N(ENTRIES)) u_pick (
    .req(hit_vec), .any(any_hit), .idx(win)
  );

  always_comb begin
    lk_hit   = lk_valid && any_hit;
    lk_miss  = lk_valid && !any_hit;
    lk_paddr = '0;
    lk_size  = 2'b00;
    if (lk_hit) begin
      lk_paddr = {frame_arr[win], lk_vaddr[OFF_4K-1:0]};
      lk_size  = size_arr[win];
    end
  end

endmodule

// File: rtl/mixed_tlb_chk.sv
module mixed_tlb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        lk_valid,
  input logic [29:0] va_low,
  input logic        lk_hit,
  input logic        lk_miss,
  input logic [29:0] pa_low,
  input logic [1:0]  lk_size,
  input logic        rf_valid,
  input logic        rf_ready
);

  logic filled;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     filled <= 1'b0;
    else if (flush)                 filled <= 1'b0;
    else if (rf_valid && rf_ready)  filled <= 1'b1;
  end

  assert_empty_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !filled |-> !lk_hit);

  assert_off4k_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_size == 2'b00) |-> pa_low[11:0] == va_low[11:0]);

  assert_off2m_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_size == 2'b01) |-> pa_low[20:0] == va_low[20:0]);

  assert_off1g_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_size == 2'b10) |-> pa_low == va_low);

  assert_no_bad_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_size != 2'b11);

  assert_hit_miss_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit ^ lk_miss));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !rf_ready);

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

endmodule

bind mixed_tlb mixed_tlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
  .va_low(lk_vaddr[29:0]), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .pa_low(lk_paddr[29:0]), .lk_size(lk_size),
  .rf_valid(rf_valid), .rf_ready(rf_ready)
);

// File: tb/mixed_tlb_test.sv
module mixed_tlb_test;

  localparam int PERIOD = 10;
  localparam int N = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        flush = 0;
  logic        lk_valid = 0;
  logic [47:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss, rf_ready;
  logic [39:0] lk_paddr;
  logic [1:0]  lk_size;
  logic        rf_valid = 0;
  logic [35:0] rf_vpn = '0;
  logic [27:0] rf_pfn = '0;
  logic [1:0]  rf_size = '0;

  int checks = 0, fails = 0;
  string cur_tag = "R1";

  always #(PERIOD/2) clk = ~clk;

  mixed_tlb uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_paddr(lk_paddr), .lk_size(lk_size), .rf_valid(rf_valid),
    .rf_ready(rf_ready), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_size(rf_size)
  );

  // reference model state
  logic [35:0] m_vpn [N];
  logic [27:0] m_pfn [N];
  logic [1:0]  m_sz  [N];
  bit          m_val [N];
  int          m_ptr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_val[i] = 0;
      m_ptr = 0;
    end else if (flush) begin
      for (int i = 0; i < N; i++) m_val[i] = 0;
      m_ptr = 0;
    end else if (rf_valid) begin
      m_vpn[m_ptr] = rf_vpn;
      m_pfn[m_ptr] = rf_pfn;
      m_sz[m_ptr]  = rf_size;
      m_val[m_ptr] = 1;
      m_ptr = (m_ptr + 1) % N;
    end
  end

  task automatic ref_lookup(input logic [47:0] va, output bit h,
                            output logic [39:0] pa, output logic [1:0] sz);
    int off;
    logic [47:0] ev;
    logic [39:0] base, lowmask;
    h = 0; pa = '0; sz = '0;
    for (int i = 0; i < N; i++) begin
      if (!h && m_val[i] && m_sz[i] != 2'b11) begin
        off = (m_sz[i] == 2'b00) ? 12 : (m_sz[i] == 2'b01) ? 21 : 30;
        ev = {m_vpn[i], 12'h000};
        if ((va >> off) == (ev >> off)) begin
          h = 1;
          sz = m_sz[i];
          base = {m_pfn[i], 12'h000};
          lowmask = (40'd1 << off) - 40'd1;
          pa = (base & ~lowmask) | (va[39:0] & lowmask);
        end
      end
    end
  endtask

  task automatic cycle(input bit lv, input logic [47:0] va, input bit rv,
                       input logic [35:0] vpn, input logic [27:0] pfn,
                       input logic [1:0] sz, input bit fl, input string tag);
    bit eh;
    logic [39:0] epa;
    logic [1:0] esz;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; rf_valid = rv; rf_vpn = vpn;
    rf_pfn = pfn; rf_size = sz; flush = fl; cur_tag = tag;
    #1;
    ref_lookup(va, eh, epa, esz);
    if (!lv) eh = 0;
    if (!eh) begin epa = '0; esz = '0; end
    checks++;
    if (lk_hit !== eh || lk_miss !== (lv && !eh) || lk_paddr !== epa ||
        lk_size !== esz || rf_ready !== !fl) begin
      fails++;
      $display("FAIL %s: hit=%0b miss=%0b pa=%h sz=%0d rdy=%0b expected hit=%0b miss=%0b pa=%h sz=%0d rdy=%0b",
               tag, lk_hit, lk_miss, lk_paddr, lk_size, rf_ready,
               eh, lv && !eh, epa, esz, !fl);
    end
  endtask

  task automatic look(input logic [47:0] va, input string tag);
    cycle(1, va, 0, '0, '0, '0, 0, tag);
  endtask

  task automatic fill(input logic [35:0] vpn, input logic [27:0] pfn,
                      input logic [1:0] sz, input string tag);
    cycle(0, '0, 1, vpn, pfn, sz, 0, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    look(48'h0000_1234_5000, "R1");
    look(48'h0000_0000_0000, "R1");
    // R2: 4 KiB slot
    fill(36'h000012345, 28'h00ABCDE, 2'b00, "R2");
    look(48'h0000_1234_57F3, "R2");
    look(48'h0000_1234_6000, "R2");
    // R3: 2 MiB slot, probe bits 20:12 that differ from stored VPN
    fill(36'h000040200, 28'h0123400, 2'b01, "R3");
    look(48'h0000_403F_F123, "R3");
    look(48'h0000_4040_0000, "R3");
    // R4: 1 GiB slot
    fill(36'h008040000, 28'h0FC0000, 2'b10, "R4");
    look(48'h0080_7FFF_FFFF, "R4");
    look(48'h0080_8000_0000, "R4");
    // R5: invalid size code
    fill(36'h000050000, 28'h0000777, 2'b11, "R5");
    look(48'h0000_5000_0000, "R5");
    // R6: idle lookup with matching address
    cycle(0, 48'h0000_1234_5000, 0, '0, '0, '0, 0, "R6");
    // R7: 2 MiB at slot 4, overlapping 4 KiB at slot 5
    fill(36'h000060000, 28'h0AAAA00, 2'b01, "R7");
    fill(36'h000060005, 28'h0BBBBBB, 2'b00, "R7");
    look(48'h0000_6000_5010, "R7");
    // R8: fill slots 6..15 then wrap onto slot 0
    for (int k = 0; k < 10; k++)
      fill(36'h100000000 + 36'(k), 28'h0200000 + 28'(k), 2'b00, "R8");
    look(48'h1000_0000_9ABC, "R8");
    fill(36'h0000ABCDE, 28'h0333333, 2'b00, "R8");
    look(48'h0000_1234_57F3, "R8");
    look(48'h0000_ABCD_E00F, "R8");
    // R9: flush with simultaneous refill
    cycle(1, 48'h0000_403F_F123, 1, 36'h000070000, 28'h1, 2'b10, 1, "R9");
    look(48'h0000_403F_F123, "R9");
    look(48'h0000_7000_0000, "R9");
    look(48'h0000_6000_5010, "R9");
    // R9/R7: pointer back at slot 0; 4 KiB now beats 2 MiB
    fill(36'h000060005, 28'h0BBBBBB, 2'b00, "R9");
    fill(36'h000060000, 28'h0AAAA00, 2'b01, "R7");
    look(48'h0000_6000_5010, "R7");
    look(48'h0000_6000_6010, "R7");
    // R8: random mixed traffic over a small address pool
    for (int k = 0; k < 600; k++) begin
      logic [47:0] va;
      logic [35:0] vp;
      va = {10'h0, 2'($urandom), 6'h0, 3'($urandom), 6'h0,
            3'($urandom), 6'h0, 12'($urandom)};
      vp = {10'h0, 2'($urandom), 6'h0, 3'($urandom), 6'h0, 3'($urandom), 6'h0};
      cycle($urandom % 4 != 0, va, $urandom % 3 == 0, vp, 28'($urandom),
            2'($urandom), $urandom % 97 == 0, "R8");
    end
    cycle(0, '0, 0, '0, '0, '0, 0, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule